// File: doc/BRIEF.md
# Lane-Mapped Matrix Multiply-Accumulate Sequencer

This block performs one wave-wide matrix multiply-accumulate, D = A x B + C, once for each of NB independent blocks. All four operands live in an internal file of 64-lane vector registers. An operand is not stored as a flat matrix. Each element (row, column, block, k) is placed on a particular register and lane, and that placement depends on M, N, K, the block count and the element width. The sequencer works through that placement while it accumulates. It does one 32-bit multiply-add per clock, and all arithmetic wraps modulo 2^32.

To use the block, write the operands into the register file through the load port. Then give the four base register numbers, the bank select bits and the fixed-source flags, and pulse `start`. Wait for `done` and read the results back through the peek port. A start that arrives while the block is running is ignored. The inputs are captured only at the start.

Top module: `mma_mac_top`

## Requirements
- R1: Element (i, j) of C and D for block b sits in relative register (i mod 4) + 4*(i/(4*MI) + G*(b/BI)) at lane j + N*((i/4) mod MI + MI*(b mod BI)). Here BI = ceil(256/(N*M)), MI = (64/BI)/N and G = M/(4*MI), using the group height 4 that applies to 32-bit elements.
- R2: Element (i, k) of A for block b sits in relative register k mod KL at lane i + M*(b + NB*(k/KL)), where KL = K/(64/(M*NB)).
- R3: Element (k, j) of B for block b sits in relative register k mod KL at lane j + N*(b + NB*(k/KL)).
- R4: Every D element equals its C element plus the sum over k of A(i,k)*B(k,j), computed in 32-bit two's complement with wrap-around.
- R5: When `bank_cd` is 1, BANK_OFF is added to both the C and D register numbers. When `bank_src[0]` is 1, BANK_OFF is added to the A register numbers. When `bank_src[1]` is 1, BANK_OFF is added to the B register numbers. Each bit acts on its own, and every register number wraps modulo NREG.
- R6: Successive registers of an operand are one index apart. When `a_fixed`, `b_fixed` or `c_fixed` is 1, the stride of that source is zero, so every relative register of it reads the base register. D always uses a stride of one.
- R7: Elements are processed one at a time: block outermost, then row, then column. Each element reads C, runs its K products, and writes D before the next element reads anything.
- R8: `done` is low after reset. It is high for exactly one cycle, on the clock edge that comes M*N*NB*(K+2) edges after the edge that captured `start`.
- R9: A `start` pulse during a run is ignored. It does not restart the run and does not cause a second `done`. Base and flag inputs that change after the capturing edge have no effect on the run.
- R10: A run writes only the D locations. Every other register and lane of the file keeps its value.
- R11: The shapes 4x4x1 with 16 blocks, 16x16x4 with 1 block and 32x32x2 with 1 block are supported. A shape whose operand sizes are not multiples of 64 lanes stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when the block is idle |
| a_base | input | log2(NREG) | Base register of A |
| b_base | input | log2(NREG) | Base register of B |
| c_base | input | log2(NREG) | Base register of C |
| d_base | input | log2(NREG) | Base register of D |
| bank_cd | input | 1 | Adds BANK_OFF to the C and D registers |
| bank_src | input | 2 | Bit 0 adds BANK_OFF to A; bit 1 adds it to B |
| a_fixed | input | 1 | Zero register stride for A |
| b_fixed | input | 1 | Zero register stride for B |
| c_fixed | input | 1 | Zero register stride for C |
| done | output | 1 | One-cycle pulse after the last D write |
| ld_we | input | 1 | Load-port write enable |
| ld_reg | input | log2(NREG) | Load-port register |
| ld_lane | input | 6 | Load-port lane |
| ld_data | input | 32 | Load-port data |
| pk_reg | input | log2(NREG) | Peek-port register |
| pk_lane | input | 6 | Peek-port lane |
| pk_data | output | 32 | Peek-port data, combinational |

## Verification
Each element takes K+2 cycles: one to read C, K to multiply-accumulate, and one to write D. The D write therefore lands on the last edge of its slot. `done` follows M*N*NB*(K+2) edges after the capturing edge, and the bench counts those edges exactly before it compares. The bench samples every output at the falling edge. It reads the file back through the combinational peek port only after `done`. The reference model replays the elements serially in block, row, column order, so results stay exact even when D overlaps a source. The bench watches `done` for 2000 cycles after the run to confirm that the ignored start launched nothing.

// File: rtl/mma_pkg.sv
package mma_pkg;
    localparam int LANES = 64;
    localparam int LW    = 6;
    localparam int EW    = 32;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FILL,
        PH_MAC,
        PH_DRAIN,
        PH_DONE
    } phase_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
endpackage

// File: rtl/mma_rf.sv
module mma_rf #(
    parameter int NREG = 32,
    parameter int NRD  = 4,
    parameter int AW   = 11
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [mma_pkg::EW-1:0]         wdata,
    input  logic [NRD-1:0][AW-1:0]         raddr,
    output logic [NRD-1:0][mma_pkg::EW-1:0] rdata
);
    localparam int DEPTH = NREG * mma_pkg::LANES;

    logic [mma_pkg::EW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/mma_layout.sv
module mma_layout #(
    parameter int M        = 16,
    parameter int N        = 16,
    parameter int K        = 4,
    parameter int NB       = 1,
    parameter int BANK_OFF = 16,
    parameter int IW       = 6,
    parameter int RW       = 5
) (
    input  logic [IW-1:0]             i,
    input  logic [IW-1:0]             j,
    input  logic [IW-1:0]             k,
    input  logic [IW-1:0]             b,
    input  logic [RW-1:0]             a_base,
    input  logic [RW-1:0]             b_base,
    input  logic [RW-1:0]             c_base,
    input  logic [RW-1:0]             d_base,
    input  logic                      bank_cd,
    input  logic [1:0]                bank_src,
    input  logic                      a_fixed,
    input  logic                      b_fixed,
    input  logic                      c_fixed,
    output logic [RW+mma_pkg::LW-1:0] a_addr,
    output logic [RW+mma_pkg::LW-1:0] b_addr,
    output logic [RW+mma_pkg::LW-1:0] c_addr,
    output logic [RW+mma_pkg::LW-1:0] d_addr
);
    localparam int LW = mma_pkg::LW;
    localparam int H  = (mma_pkg::EW == 64) ? 1 : 4;
    localparam int BI = mma_pkg::ceil_div(64, (N * M) / H);
    localparam int MI = (64 / BI) / N;
    localparam int G  = M / (H * MI);
    localparam int KL = K / (64 / (M * NB));

    int ii, jj, kk, bb;
    int cd_rel, cd_ln, src_rel, a_ln, b_ln;
    int off_cd, off_a, off_b;
    int ra, rb, rc, rd;

    always_comb begin
        ii      = 32'(i);
        jj      = 32'(j);
        kk      = 32'(k);
        bb      = 32'(b);
        cd_rel  = (ii % H) + H * (ii / (H * MI) + G * (bb / BI));
        cd_ln   = jj + N * (((ii / H) % MI) + MI * (bb % BI));
        src_rel = kk % KL;
        a_ln    = ii + M * (bb + NB * (kk / KL));
        b_ln    = jj + N * (bb + NB * (kk / KL));
        off_cd  = bank_cd     ? BANK_OFF : 0;
        off_a   = bank_src[0] ? BANK_OFF : 0;
        off_b   = bank_src[1] ? BANK_OFF : 0;
        ra      = 32'(a_base) + off_a  + (a_fixed ? 0 : src_rel);
        rb      = 32'(b_base) + off_b  + (b_fixed ? 0 : src_rel);
        rc      = 32'(c_base) + off_cd + (c_fixed ? 0 : cd_rel);
        rd      = 32'(d_base) + off_cd + cd_rel;
        a_addr  = {RW'(ra), LW'(a_ln)};
        b_addr  = {RW'(rb), LW'(b_ln)};
        c_addr  = {RW'(rc), LW'(cd_ln)};
        d_addr  = {RW'(rd), LW'(cd_ln)};
    end
endmodule

// File: rtl/mma_seq.sv
module mma_seq #(
    parameter int M  = 16,
    parameter int N  = 16,
    parameter int K  = 4,
    parameter int NB = 1,
    parameter int IW = 6,
    parameter int RW = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [RW-1:0]          a_base,
    input  logic [RW-1:0]          b_base,
    input  logic [RW-1:0]          c_base,
    input  logic [RW-1:0]          d_base,
    input  logic                   bank_cd,
    input  logic [1:0]             bank_src,
    input  logic                   a_fixed,
    input  logic                   b_fixed,
    input  logic                   c_fixed,
    input  logic [mma_pkg::EW-1:0] a_val,
    input  logic [mma_pkg::EW-1:0] b_val,
    input  logic [mma_pkg::EW-1:0] c_val,
    output logic [IW-1:0]          i_o,
    output logic [IW-1:0]          j_o,
    output logic [IW-1:0]          k_o,
    output logic [IW-1:0]          b_o,
    output logic [RW-1:0]          a_base_o,
    output logic [RW-1:0]          b_base_o,
    output logic [RW-1:0]          c_base_o,
    output logic [RW-1:0]          d_base_o,
    output logic                   bank_cd_o,
    output logic [1:0]             bank_src_o,
    output logic                   a_fixed_o,
    output logic                   b_fixed_o,
    output logic                   c_fixed_o,
    output logic                   wr_en,
    output logic [mma_pkg::EW-1:0] wr_data,
    output logic                   busy,
    output logic                   done
);
    import mma_pkg::*;

    localparam logic [IW-1:0] ONE    = IW'(1);
    localparam logic [IW-1:0] M_LAST = IW'(M - 1);
    localparam logic [IW-1:0] N_LAST = IW'(N - 1);
    localparam logic [IW-1:0] K_LAST = IW'(K - 1);
    localparam logic [IW-1:0] B_LAST = IW'(NB - 1);

    typedef struct packed {
        logic [RW-1:0] ab;
        logic [RW-1:0] bb;
        logic [RW-1:0] cb;
        logic [RW-1:0] db;
        logic          bcd;
        logic [1:0]    bsrc;
        logic          af;
        logic          bf;
        logic          cf;
    } cfg_t;

    typedef struct packed {
        phase_t        ph;
        logic [IW-1:0] i;
        logic [IW-1:0] j;
        logic [IW-1:0] k;
        logic [IW-1:0] b;
        logic [EW-1:0] acc;
        cfg_t          cfg;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph       = PH_FILL;
                    st_d.i        = '0;
                    st_d.j        = '0;
                    st_d.k        = '0;
                    st_d.b        = '0;
                    st_d.cfg.ab   = a_base;
                    st_d.cfg.bb   = b_base;
                    st_d.cfg.cb   = c_base;
                    st_d.cfg.db   = d_base;
                    st_d.cfg.bcd  = bank_cd;
                    st_d.cfg.bsrc = bank_src;
                    st_d.cfg.af   = a_fixed;
                    st_d.cfg.bf   = b_fixed;
                    st_d.cfg.cf   = c_fixed;
                end
            end
            PH_FILL: begin
                st_d.acc = c_val;
                st_d.k   = '0;
                st_d.ph  = PH_MAC;
            end
            PH_MAC: begin
                st_d.acc = st_q.acc + a_val * b_val;
                if (st_q.k == K_LAST) begin
                    st_d.ph = PH_DRAIN;
                end else begin
                    st_d.k = st_q.k + ONE;
                end
            end
            PH_DRAIN: begin
                st_d.ph = PH_FILL;
                if (st_q.j == N_LAST) begin
                    st_d.j = '0;
                    if (st_q.i == M_LAST) begin
                        st_d.i = '0;
                        if (st_q.b == B_LAST) begin
                            st_d.ph = PH_DONE;
                        end else begin
                            st_d.b = st_q.b + ONE;
                        end
                    end else begin
                        st_d.i = st_q.i + ONE;
                    end
                end else begin
                    st_d.j = st_q.j + ONE;
                end
            end
            PH_DONE: begin
                st_d.ph = PH_IDLE;
            end
            default: begin
                st_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign i_o        = st_q.i;
    assign j_o        = st_q.j;
    assign k_o        = st_q.k;
    assign b_o        = st_q.b;
    assign a_base_o   = st_q.cfg.ab;
    assign b_base_o   = st_q.cfg.bb;
    assign c_base_o   = st_q.cfg.cb;
    assign d_base_o   = st_q.cfg.db;
    assign bank_cd_o  = st_q.cfg.bcd;
    assign bank_src_o = st_q.cfg.bsrc;
    assign a_fixed_o  = st_q.cfg.af;
    assign b_fixed_o  = st_q.cfg.bf;
    assign c_fixed_o  = st_q.cfg.cf;
    assign wr_en      = (st_q.ph == PH_DRAIN);
    assign wr_data    = st_q.acc;
    assign busy       = (st_q.ph != PH_IDLE);
    assign done       = (st_q.ph == PH_DONE);
endmodule

// File: rtl/mma_mac_top.sv
module mma_mac_top #(
    parameter int M        = 16,
    parameter int N        = 16,
    parameter int K        = 4,
    parameter int NB       = 1,
    parameter int NREG     = 32,
    parameter int BANK_OFF = 16,
    localparam int RW      = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [RW-1:0] a_base,
    input  logic [RW-1:0] b_base,
    input  logic [RW-1:0] c_base,
    input  logic [RW-1:0] d_base,
    input  logic          bank_cd,
    input  logic [1:0]    bank_src,
    input  logic          a_fixed,
    input  logic          b_fixed,
    input  logic          c_fixed,
    output logic          done,
    input  logic          ld_we,
    input  logic [RW-1:0] ld_reg,
    input  logic [5:0]    ld_lane,
    input  logic [31:0]   ld_data,
    input  logic [RW-1:0] pk_reg,
    input  logic [5:0]    pk_lane,
    output logic [31:0]   pk_data
);
    import mma_pkg::*;

    localparam int IW   = $clog2(max4(M, N, K, NB)) + 1;
    localparam int AW   = RW + LW;
    localparam int NRD  = 4;
    localparam int CFGW = 4 * RW + 6;

    if (((M * N * NB) % 64) != 0 || ((M * K * NB) % 64) != 0 ||
        ((K * N * NB) % 64) != 0 || (64 % (M * NB)) != 0 ||
        (1 << RW) != NREG) begin : g_bad_shape
        $error("mma_mac_top: operand sizes must fill whole 64-lane registers");
    end

    logic [IW-1:0]          idx_i, idx_j, idx_k, idx_b;
    logic [RW-1:0]          q_ab, q_bb, q_cb, q_db;
    logic                   q_bcd, q_af, q_bf, q_cf;
    logic [1:0]             q_bsrc;
    logic                   seq_wr, seq_busy;
    logic [EW-1:0]          seq_wdata;
    logic [AW-1:0]          a_addr, b_addr, c_addr, d_addr;
    logic [NRD-1:0][AW-1:0] rd_addr;
    logic [NRD-1:0][EW-1:0] rd_data;
    logic                   rf_we;
    logic [AW-1:0]          rf_waddr;
    logic [EW-1:0]          rf_wdata;
    logic [CFGW-1:0]        cfg_flat;

    mma_seq #(.M(M), .N(N), .K(K), .NB(NB), .IW(IW), .RW(RW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .a_base     (a_base),
        .b_base     (b_base),
        .c_base     (c_base),
        .d_base     (d_base),
        .bank_cd    (bank_cd),
        .bank_src   (bank_src),
        .a_fixed    (a_fixed),
        .b_fixed    (b_fixed),
        .c_fixed    (c_fixed),
        .a_val      (rd_data[1]),
        .b_val      (rd_data[2]),
        .c_val      (rd_data[0]),
        .i_o        (idx_i),
        .j_o        (idx_j),
        .k_o        (idx_k),
        .b_o        (idx_b),
        .a_base_o   (q_ab),
        .b_base_o   (q_bb),
        .c_base_o   (q_cb),
        .d_base_o   (q_db),
        .bank_cd_o  (q_bcd),
        .bank_src_o (q_bsrc),
        .a_fixed_o  (q_af),
        .b_fixed_o  (q_bf),
        .c_fixed_o  (q_cf),
        .wr_en      (seq_wr),
        .wr_data    (seq_wdata),
        .busy       (seq_busy),
        .done       (done)
    );

    mma_layout #(.M(M), .N(N), .K(K), .NB(NB), .BANK_OFF(BANK_OFF), .IW(IW), .RW(RW)) u_layout (
        .i        (idx_i),
        .j        (idx_j),
        .k        (idx_k),
        .b        (idx_b),
        .a_base   (q_ab),
        .b_base   (q_bb),
        .c_base   (q_cb),
        .d_base   (q_db),
        .bank_cd  (q_bcd),
        .bank_src (q_bsrc),
        .a_fixed  (q_af),
        .b_fixed  (q_bf),
        .c_fixed  (q_cf),
        .a_addr   (a_addr),
        .b_addr   (b_addr),
        .c_addr   (c_addr),
        .d_addr   (d_addr)
    );

    assign rd_addr[0] = c_addr;
    assign rd_addr[1] = a_addr;
    assign rd_addr[2] = b_addr;
    assign rd_addr[3] = {pk_reg, pk_lane};

    assign rf_we    = seq_wr | ld_we;
    assign rf_waddr = seq_wr ? d_addr : {ld_reg, ld_lane};
    assign rf_wdata = seq_wr ? seq_wdata : ld_data;

    mma_rf #(.NREG(NREG), .NRD(NRD), .AW(AW)) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign pk_data  = rd_data[3];
    assign cfg_flat = {q_ab, q_bb, q_cb, q_db, q_bcd, q_bsrc, q_af, q_bf, q_cf};
endmodule

// File: rtl/mma_chk.sv
module mma_chk #(
    parameter int CW = 26
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          wr_en,
    input logic [CW-1:0] cfg
);
    // R8: done lasts one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done follows the final D write
    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));

    // R9: captured operands are frozen while running
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg));

    // R9: a start seen while idle launches a run
    assert_start_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R7: D writes are separated by the read and multiply steps of the next element
    assert_write_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

bind mma_mac_top mma_chk #(.CW(CFGW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (seq_busy),
    .done  (done),
    .wr_en (seq_wr),
    .cfg   (cfg_flat)
);

// File: tb/mma_mac_top_test.sv
module mma_run #(
    parameter int M        = 16,
    parameter int N        = 16,
    parameter int K        = 4,
    parameter int NB       = 1,
    parameter int NREG     = 32,
    parameter int BANK_OFF = 16,
    parameter bit IGN      = 1'b0,
    parameter int SEED     = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic fin,
    output int   tests,
    output int   fails
);
    localparam int RW = $clog2(NREG);
    localparam int H  = 4;
    localparam int NM = (N * M) / H;
    localparam int BI = (64 + NM - 1) / NM;
    localparam int MI = (64 / BI) / N;
    localparam int G  = M / (H * MI);
    localparam int KL = K / (64 / (M * NB));
    localparam int CS = (M * N * NB) / 64;
    localparam int E  = M * N * NB;

    logic          start, bank_cd, a_fixed, b_fixed, c_fixed, done, ld_we;
    logic [RW-1:0] a_base, b_base, c_base, d_base, ld_reg, pk_reg;
    logic [1:0]    bank_src;
    logic [5:0]    ld_lane, pk_lane;
    logic [31:0]   ld_data, pk_data;
    logic [31:0]   sh [NREG*64];

    mma_mac_top #(.M(M), .N(N), .K(K), .NB(NB), .NREG(NREG), .BANK_OFF(BANK_OFF)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_base(a_base), .b_base(b_base), .c_base(c_base), .d_base(d_base),
        .bank_cd(bank_cd), .bank_src(bank_src),
        .a_fixed(a_fixed), .b_fixed(b_fixed), .c_fixed(c_fixed),
        .done(done), .ld_we(ld_we), .ld_reg(ld_reg), .ld_lane(ld_lane), .ld_data(ld_data),
        .pk_reg(pk_reg), .pk_lane(pk_lane), .pk_data(pk_data)
    );

    function automatic int cd_reg(input int i, input int b);
        return (i % H) + H * (i / (H * MI) + G * (b / BI));
    endfunction
    function automatic int cd_lane(input int i, input int j, input int b);
        return j + N * (((i / H) % MI) + MI * (b % BI));
    endfunction
    function automatic int ab_reg(input int k);
        return k % KL;
    endfunction
    function automatic int a_lane(input int i, input int k, input int b);
        return i + M * (b + NB * (k / KL));
    endfunction
    function automatic int b_lane(input int j, input int k, input int b);
        return j + N * (b + NB * (k / KL));
    endfunction
    function automatic int loc(input int r, input int l);
        return (r % NREG) * 64 + l;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %0dx%0dx%0d/%0d %s actual %0h expected %0h",
                     tag, M, N, K, NB, what, act, exp);
        end
    endtask

    task automatic fill();
        for (int r = 0; r < NREG; r++) begin
            for (int l = 0; l < 64; l++) begin
                @(negedge clk);
                ld_we   = 1'b1;
                ld_reg  = RW'(r);
                ld_lane = 6'(l);
                ld_data = $urandom;
                sh[r*64+l] = ld_data;
            end
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic model(input int ab, input int bb, input int cb, input int db,
                         input bit bcd, input bit [1:0] bs, input bit af, input bit bf,
                         input bit cf);
        int oc, oa, ob;
        logic [31:0] acc;
        oc = bcd ? BANK_OFF : 0;
        oa = bs[0] ? BANK_OFF : 0;
        ob = bs[1] ? BANK_OFF : 0;
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < M; i++) begin
                for (int j = 0; j < N; j++) begin
                    acc = sh[loc(cb + oc + (cf ? 0 : cd_reg(i, b)), cd_lane(i, j, b))];
                    for (int k = 0; k < K; k++) begin
                        acc = acc + sh[loc(ab + oa + (af ? 0 : ab_reg(k)), a_lane(i, k, b))]
                                  * sh[loc(bb + ob + (bf ? 0 : ab_reg(k)), b_lane(j, k, b))];
                    end
                    sh[loc(db + oc + cd_reg(i, b), cd_lane(i, j, b))] = acc;
                end
            end
        end
    endtask

    task automatic run_case(input string tag, input int ab, input int bb, input int cb,
                            input int db, input bit bcd, input bit [1:0] bs, input bit af,
                            input bit bf, input bit cf, input bit ign);
        int t;
        bit quiet;
        fill();
        @(negedge clk);
        a_base   = RW'(ab);
        b_base   = RW'(bb);
        c_base   = RW'(cb);
        d_base   = RW'(db);
        bank_cd  = bcd;
        bank_src = bs;
        a_fixed  = af;
        b_fixed  = bf;
        c_fixed  = cf;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < E * (K + 2) + 50) begin
            @(posedge clk);
            t++;
            @(negedge clk);
            if (ign && t == 100) begin
                start  = 1'b1;
                d_base = RW'(db + 3);
                a_base = RW'(ab + 5);
            end
            if (ign && t == 101) begin
                start  = 1'b0;
                d_base = RW'(db);
                a_base = RW'(ab);
            end
        end
        check("R8", "edges to done", 32'(t), 32'(E * (K + 2)));
        @(posedge clk);
        @(negedge clk);
        check("R8", "done after pulse", {31'd0, done}, 32'd0);
        model(ab, bb, cb, db, bcd, bs, af, bf, cf);
        for (int idx = 0; idx < NREG * 64; idx++) begin
            pk_reg  = RW'(idx / 64);
            pk_lane = 6'(idx % 64);
            #1;
            check(tag, "file word", pk_data, sh[idx]);
        end
        if (ign) begin
            quiet = 1'b1;
            for (int c = 0; c < 2000; c++) begin
                @(negedge clk);
                if (done) quiet = 1'b0;
            end
            check("R9", "done after ignored start", {31'd0, quiet}, 32'd1);
        end
    endtask

    initial begin
        fin = 1'b0; tests = 0; fails = 0;
        start = 1'b0; bank_cd = 1'b0; bank_src = 2'b00;
        a_fixed = 1'b0; b_fixed = 1'b0; c_fixed = 1'b0;
        a_base = '0; b_base = '0; c_base = '0; d_base = '0;
        ld_we = 1'b0; ld_reg = '0; ld_lane = '0; ld_data = '0;
        pk_reg = '0; pk_lane = '0;
        void'($urandom(SEED));
        wait (rst_n == 1'b1);
        @(negedge clk);
        check("R8", "done at reset", {31'd0, done}, 32'd0);
        // R1 R2 R3 R4 R7 R10 R11: plain layout; the large shape writes D in place over C
        run_case("R1 R2 R3 R4 R7 R10 R11", 0, 1, 4, (CS <= 8) ? 4 + CS : 4,
                 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, IGN);
        // R5: C/D bank offset together with the A bank bit
        run_case("R5 R4", 0, 1, 4, (CS <= 8) ? 4 + CS : 4,
                 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5 R6: B bank bit alone, zero-stride sources
        run_case("R5 R6", 0, 1, 4, 4 + CS, 1'b0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0);
        // R5 R6 R7 R10: random bases and select bits
        for (int n = 0; n < 2; n++) begin
            run_case("R5 R6 R7 R10", $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1),
                     $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1),
                     1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        end
        fin = 1'b1;
    end
endmodule

module mma_mac_top_test;
    localparam int WD_CYCLES = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f0, f1, f2;
    int   t0, t1, t2, e0, e1, e2;
    bit   wd_hit = 1'b0;

    always #10 clk = ~clk;

    mma_run #(.M(16), .N(16), .K(4), .NB(1),  .NREG(32), .BANK_OFF(16), .IGN(1'b1), .SEED(11))
        u_mid   (.clk(clk), .rst_n(rst_n), .fin(f0), .tests(t0), .fails(e0));
    mma_run #(.M(4),  .N(4),  .K(1), .NB(16), .NREG(32), .BANK_OFF(16), .IGN(1'b0), .SEED(23))
        u_small (.clk(clk), .rst_n(rst_n), .fin(f1), .tests(t1), .fails(e1));
    mma_run #(.M(32), .N(32), .K(2), .NB(1),  .NREG(64), .BANK_OFF(32), .IGN(1'b0), .SEED(37))
        u_big   (.clk(clk), .rst_n(rst_n), .fin(f2), .tests(t2), .fails(e2));

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
    end

    initial begin
        int total, bad;
        fork
            begin
                #1;
                wait (f0 && f1 && f2);
            end
            begin
                repeat (WD_CYCLES) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        total = t0 + t1 + t2;
        bad   = e0 + e1 + e2;
        if (wd_hit) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual timeout expected done");
        end
        $display("  [TB] %0d tests run, %0d failed", total, bad);
        $finish;
    end
endmodule